// File: doc/BRIEF.md
# DAC Channel Source Selector

This block sits in front of one DAC channel and decides, on every sample strobe, which 16-bit word goes to the converter. It can pass through externally generated data (a tone sample, DMA data, loopback data from the receive side, a device-specific PN word), play back a pair of fixed pattern words, emit zero, or produce test data of its own. That test data comes from PN7 and PN15 generators, in true and inverted form, and from two ramp styles.

A 4-bit code chooses the source. Two override inputs can force the loopback or the device PN source without changing the code. If both overrides are set, they cancel and the code is used as programmed. In complex mode the output words carry an I/Q tag that alternates from sample to sample, and a swap input exchanges which slot is called I and which is called Q. The result appears one clock after the strobe.

Top module: `dac_src_sel`

## Requirements
- R1: Source code 0 outputs `tone_data`, code 2 outputs `dma_data`, and code 3 outputs 16'h0000.
- R2: Code 1 outputs `patt_a` when the internal slot bit is 0 and `patt_b` when it is 1. The slot bit is 0 after reset and toggles on every strobe.
- R3: Code 6 outputs the next 16 bits of a PN7 sequence using x^7+x^6+1 (feedback = state[6] XOR state[5], then shift left and insert the feedback). The first bit generated goes to bit 15, and the state reseeds to all ones on reset. Code 4 outputs the bitwise complement of that word.
- R4: Code 7 outputs the PN15 word built the same way with x^15+x^14+1 (feedback = state[14] XOR state[13]). Code 5 outputs its complement.
- R5: Code B outputs a 16-bit counter that starts at 0 and rises by 1 per strobe. Code A repeats a 4-bit counter in all four nibbles; that counter also starts at 0 and rises by 1 per strobe.
- R6: With `lb_force`=1 and `pn_force`=0, the output is `lpbk_data` (code 8). With `pn_force`=1 and `lb_force`=0, the output is `devpn_data` (code 9). In both cases the code on `src_sel` is ignored.
- R7: With both `lb_force` and `pn_force` set, the programmed `src_sel` code is used.
- R8: Codes C through F output 16'h0000.
- R9: After a strobe, `out_data` and `out_valid`=1 appear after exactly one clock edge. Without a strobe, `out_valid` is 0 and `out_data` and `out_q` hold their values.
- R10: `out_q` is 0 on every strobe when `iq_mode`=0. When `iq_mode`=1, `out_q` equals the slot bit XOR `iq_swap`.
- R11: The PN generators, both counters and the slot bit advance on every strobe, whichever source is selected.
- R12: After reset, `out_data`=0, `out_valid`=0 and `out_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample strobe |
| src_sel | input | 4 | Programmed source code |
| lb_force | input | 1 | Force the loopback source |
| pn_force | input | 1 | Force the device PN source |
| iq_mode | input | 1 | Complex (I/Q) mode |
| iq_swap | input | 1 | Exchange I and Q slots in complex mode |
| tone_data | input | 16 | Tone generator sample |
| patt_a | input | 16 | Pattern word, first slot |
| patt_b | input | 16 | Pattern word, second slot |
| dma_data | input | 16 | DMA sample |
| lpbk_data | input | 16 | Loopback sample from the receive path |
| devpn_data | input | 16 | Device-specific PN word |
| out_data | output | 16 | Selected sample |
| out_valid | output | 1 | Strobe delayed by one clock |
| out_q | output | 1 | I/Q slot tag of `out_data` (1 = Q) |

## Verification
Two functions can act in the same cycle. The override logic can collide with the programmed code, and a source change can coincide with the free-running generators advancing. The bench provokes the first by raising both overrides together with codes that would otherwise be overridden, and judges the result against the programmed code. It provokes the second by switching between PN, ramp and pass-through codes on consecutive strobes. Each PN or ramp word must then match a bench model that advanced on every strobe, including the strobes where a different source was selected.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;

  typedef enum logic [3:0] {
    SRC_TONE     = 4'h0,
    SRC_PATT     = 4'h1,
    SRC_DMA      = 4'h2,
    SRC_ZERO     = 4'h3,
    SRC_PN7_INV  = 4'h4,
    SRC_PN15_INV = 4'h5,
    SRC_PN7      = 4'h6,
    SRC_PN15     = 4'h7,
    SRC_LPBK     = 4'h8,
    SRC_DEVPN    = 4'h9,
    SRC_NIBRAMP  = 4'hA,
    SRC_RAMP     = 4'hB
  } src_code_e;

  // Overrides act only when exactly one of them is set.
  function automatic logic [3:0] eff_select(input logic [3:0] sel,
                                            input logic lb, input logic pn);
    if (lb && !pn)      return SRC_LPBK;
    else if (pn && !lb) return SRC_DEVPN;
    else                return sel;
  endfunction

  // Tag for the current word: 1 marks the Q slot.
  function automatic logic iq_tag(input logic mode, input logic slot,
                                  input logic swap);
    return mode & (slot ^ swap);
  endfunction

endpackage

// File: rtl/dac_src_pn.sv
module dac_src_pn #(
  parameter int LEN   = 7,
  parameter int TAP_A = 7,
  parameter int TAP_B = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [DW-1:0] word
);
  logic [LEN-1:0] state;
  logic [LEN-1:0] nxt;

  // DW serial steps, flattened into one cycle; the first bit lands at the MSB.
  always_comb begin
    logic [LEN-1:0] s;
    logic           fb;
    s    = state;
    word = '0;
    for (int i = 0; i < DW; i++) begin
      fb            = s[TAP_A-1] ^ s[TAP_B-1];
      word[DW-1-i]  = fb;
      s             = {s[LEN-2:0], fb};
    end
    nxt = s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= '1;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/dac_src_ramp.sv
module dac_src_ramp #(
  parameter int DW = 16,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [DW-1:0] ramp_word,
  output logic [DW-1:0] nib_word
);
  localparam int NCOPY = DW / NW;

  logic [DW-1:0] ramp_cnt;
  logic [NW-1:0] nib_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_cnt <= '0;
      nib_cnt  <= '0;
    end else if (adv) begin
      ramp_cnt <= ramp_cnt + 1'b1;
      nib_cnt  <= nib_cnt + 1'b1;
    end
  end

  assign ramp_word = ramp_cnt;

  for (genvar g = 0; g < NCOPY; g++) begin : g_nib
    assign nib_word[g*NW +: NW] = nib_cnt;
  end
endmodule

// File: rtl/dac_src_sel.sv
module dac_src_sel
  import dac_src_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic [3:0]    src_sel,
  input  logic          lb_force,
  input  logic          pn_force,
  input  logic          iq_mode,
  input  logic          iq_swap,
  input  logic [DW-1:0] tone_data,
  input  logic [DW-1:0] patt_a,
  input  logic [DW-1:0] patt_b,
  input  logic [DW-1:0] dma_data,
  input  logic [DW-1:0] lpbk_data,
  input  logic [DW-1:0] devpn_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_q
);
  logic [3:0]    eff_sel;
  logic [DW-1:0] pn7_word, pn15_word, ramp_word, nib_word;
  logic [DW-1:0] mux_word;
  logic          slot;

  assign eff_sel = eff_select(src_sel, lb_force, pn_force);

  dac_src_pn #(.LEN(7), .TAP_A(7), .TAP_B(6), .DW(DW)) u_pn7 (
    .clk(clk), .rst_n(rst_n), .adv(sample_en), .word(pn7_word));

  dac_src_pn #(.LEN(15), .TAP_A(15), .TAP_B(14), .DW(DW)) u_pn15 (
    .clk(clk), .rst_n(rst_n), .adv(sample_en), .word(pn15_word));

  dac_src_ramp #(.DW(DW), .NW(4)) u_ramp (
    .clk(clk), .rst_n(rst_n), .adv(sample_en),
    .ramp_word(ramp_word), .nib_word(nib_word));

  always_comb begin
    case (eff_sel)
      SRC_TONE:     mux_word = tone_data;
      SRC_PATT:     mux_word = slot ? patt_b : patt_a;
      SRC_DMA:      mux_word = dma_data;
      SRC_ZERO:     mux_word = '0;
      SRC_PN7_INV:  mux_word = ~pn7_word;
      SRC_PN15_INV: mux_word = ~pn15_word;
      SRC_PN7:      mux_word = pn7_word;
      SRC_PN15:     mux_word = pn15_word;
      SRC_LPBK:     mux_word = lpbk_data;
      SRC_DEVPN:    mux_word = devpn_data;
      SRC_NIBRAMP:  mux_word = nib_word;
      SRC_RAMP:     mux_word = ramp_word;
      default:      mux_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_q     <= 1'b0;
      slot      <= 1'b0;
    end else begin
      out_valid <= sample_en;
      if (sample_en) begin
        out_data <= mux_word;
        out_q    <= iq_tag(iq_mode, slot, iq_swap);
        slot     <= ~slot;
      end
    end
  end
endmodule

// File: rtl/dac_src_sel_chk.sv
module dac_src_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sample_en,
  input logic [3:0]  src_sel,
  input logic        lb_force,
  input logic        pn_force,
  input logic        iq_mode,
  input logic [15:0] tone_data,
  input logic [15:0] lpbk_data,
  input logic [15:0] devpn_data,
  input logic [15:0] out_data,
  input logic        out_valid,
  input logic        out_q
);
  AST_VALID_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> out_valid); // R9
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> (!out_valid && $stable(out_data) && $stable(out_q))); // R9
  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !lb_force && !pn_force && src_sel == 4'h3) |=> out_data == 16'h0); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !lb_force && !pn_force && src_sel >= 4'hC) |=> out_data == 16'h0); // R8
  AST_LB_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && lb_force && !pn_force) |=> out_data == $past(lpbk_data)); // R6
  AST_PN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && pn_force && !lb_force) |=> out_data == $past(devpn_data)); // R6
  AST_BOTH_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && pn_force && lb_force && src_sel == 4'h0) |=> out_data == $past(tone_data)); // R7
  AST_REAL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !iq_mode) |=> !out_q); // R10
endmodule

bind dac_src_sel dac_src_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .src_sel(src_sel),
  .lb_force(lb_force), .pn_force(pn_force), .iq_mode(iq_mode),
  .tone_data(tone_data), .lpbk_data(lpbk_data), .devpn_data(devpn_data),
  .out_data(out_data), .out_valid(out_valid), .out_q(out_q));

// File: tb/dac_src_sel_bench.sv
module dac_src_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic [3:0]  src_sel = '0;
  logic        lb_force = 1'b0, pn_force = 1'b0, iq_mode = 1'b0, iq_swap = 1'b0;
  logic [15:0] tone_data = '0, patt_a = '0, patt_b = '0, dma_data = '0;
  logic [15:0] lpbk_data = '0, devpn_data = '0;
  logic [15:0] out_data;
  logic        out_valid, out_q;

  int checks = 0;
  int errors = 0;

  // bench model state
  int unsigned m_pn7, m_pn15, m_ramp, m_nib;
  logic m_slot;
  logic [15:0] e_data;
  logic e_q;

  always #2ns clk = ~clk;

  dac_src_sel u_dac_src_sel (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .src_sel(src_sel),
    .lb_force(lb_force), .pn_force(pn_force), .iq_mode(iq_mode), .iq_swap(iq_swap),
    .tone_data(tone_data), .patt_a(patt_a), .patt_b(patt_b), .dma_data(dma_data),
    .lpbk_data(lpbk_data), .devpn_data(devpn_data),
    .out_data(out_data), .out_valid(out_valid), .out_q(out_q));

  // Integer-arithmetic restatement of the LFSR word: bits appended at the LSB.
  function automatic logic [15:0] pn_word(inout int unsigned st, input int len);
    int unsigned w = 0;
    int unsigned mask = (1 << len) - 1;
    for (int i = 0; i < 16; i++) begin
      int unsigned fb = ((st >> (len - 1)) ^ (st >> (len - 2))) & 1;
      st = ((st << 1) | fb) & mask;
      w  = (w << 1) | fb;
    end
    return w[15:0];
  endfunction

  function automatic string req_of(input int code, input logic lb, input logic pn);
    if (lb && pn) return "R7";
    if (lb || pn) return "R6";
    case (code)
      0, 2, 3: return "R1";
      1:       return "R2";
      4, 6:    return "R3";
      5, 7:    return "R4";
      10, 11:  return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pn7 = 32'h7f; m_pn15 = 32'h7fff; m_ramp = 0; m_nib = 0; m_slot = 1'b0;
    e_data = '0; e_q = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample_en = 1'b0;
    model_reset();
    @(negedge clk);
    check("R12", "reset data", {16'h0, out_data}, 32'h0);
    check("R12", "reset valid", {31'h0, out_valid}, 32'h0);
    check("R12", "reset q", {31'h0, out_q}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic en, input logic [3:0] sel, input logic lb,
                      input logic pn, input logic iq, input logic sw);
    int code;
    logic [15:0] w7, w15;
    string req;
    @(negedge clk);
    sample_en = en; src_sel = sel; lb_force = lb; pn_force = pn;
    iq_mode = iq; iq_swap = sw;
    tone_data = $urandom; patt_a = $urandom; patt_b = $urandom;
    dma_data = $urandom; lpbk_data = $urandom; devpn_data = $urandom;
    code = (lb && !pn) ? 8 : (pn && !lb) ? 9 : int'(sel);
    req = req_of(int'(sel), lb, pn);
    if (en) begin
      w7  = pn_word(m_pn7, 7);
      w15 = pn_word(m_pn15, 15);
      case (code)
        0: e_data = tone_data;
        1: e_data = m_slot ? patt_b : patt_a;
        2: e_data = dma_data;
        4: e_data = ~w7;
        5: e_data = ~w15;
        6: e_data = w7;
        7: e_data = w15;
        8: e_data = lpbk_data;
        9: e_data = devpn_data;
        10: e_data = {4{m_nib[3:0]}};
        11: e_data = m_ramp[15:0];
        default: e_data = 16'h0;
      endcase
      e_q = iq ? (m_slot ^ sw) : 1'b0;
      m_slot = ~m_slot;
      m_ramp = (m_ramp + 1) & 32'hffff;
      m_nib  = (m_nib + 1) & 32'hf;
    end
    @(posedge clk);
    #1ns;
    check(en ? req : "R9", "data", {16'h0, out_data}, {16'h0, e_data});
    check("R9", "valid", {31'h0, out_valid}, {31'h0, en});
    check("R10", "q tag", {31'h0, out_q}, {31'h0, e_q});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();
    // R3 first PN7 word after reseed, then R4 PN15, generators advanced by R11
    step(1, 4'h6, 0, 0, 0, 0);
    step(1, 4'h7, 0, 0, 0, 0);
    step(1, 4'h4, 0, 0, 0, 0);
    step(1, 4'h5, 0, 0, 0, 0);
    // R5 ramps interleaved with other sources (R11 continuity)
    step(1, 4'hB, 0, 0, 0, 0);
    step(1, 4'h0, 0, 0, 0, 0);
    step(1, 4'hA, 0, 0, 0, 0);
    step(1, 4'hB, 0, 0, 0, 0);
    // R2 pattern alternation
    step(1, 4'h1, 0, 0, 0, 0);
    step(1, 4'h1, 0, 0, 0, 0);
    // R6 single overrides, R7 both set
    step(1, 4'h2, 1, 0, 0, 0);
    step(1, 4'h2, 0, 1, 0, 0);
    step(1, 4'h2, 1, 1, 0, 0);
    step(1, 4'h6, 1, 1, 0, 0);
    // R8 unused codes, R9 idle hold
    for (int c = 12; c < 16; c++) step(1, c[3:0], 0, 0, 0, 0);
    step(0, 4'h0, 0, 0, 0, 0);
    step(0, 4'h7, 1, 0, 1, 1);
    // R10 complex mode with and without swap
    step(1, 4'h3, 0, 0, 1, 0);
    step(1, 4'h3, 0, 0, 1, 0);
    step(1, 4'h3, 0, 0, 1, 1);
    step(1, 4'h3, 0, 0, 1, 1);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, 4'($urandom), ($urandom % 8) == 0,
           ($urandom % 8) == 0, 1'($urandom), 1'($urandom));
      if (n == 1500) do_reset();  // R12 reseed mid-run
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule